// File: doc/BRIEF.md
# Privilege and Interrupt Gate for the System Control Status Word

This block holds the processor's system-control status word and derives three control decisions from it. The first is whether a hardware interrupt may be signalled to the pipeline. The second is whether the core currently runs with user privilege. The third is whether a decoded system-coprocessor instruction must trap because it is not usable at that privilege.

Software writes the status word through a simple write strobe. Only the implemented bits are kept, and a read returns exactly what is stored. The pending-interrupt lines of the cause word and a debug-mode level come from neighbouring logic. Exception entry and return sequencing live outside this block; they reach it only through status writes and the debug flag.

All pins are plain control or status pins; there is no streamed data, so no valid/ready handshake is used.

Top module: `cp0_stat_gate`

## Requirements
- R1: `irq_req` is a register. After each rising edge it equals 1 exactly when, at that edge, (status[15:8] AND `cause_ip`) is nonzero, status bit 0 (interrupt enable) is 1, status bit 1 (exception level) is 0, status bit 2 (error level) is 0 and `dbg_mode` is 0. A status write therefore shows on `irq_req` one cycle after the stored value changes.
- R2: When the enable conditions of R1 fail, `irq_req` is driven to 0 at the next edge, even while an unmasked pending line stays high.
- R3: A write stores `st_wr_data & 32'hF878_FF17`. `st_rd_data` always returns the stored value unchanged, so bits outside that mask read 0.
- R4: `user_mode` is combinational and is 1 exactly when status bit 4 is 1, status bits 1 and 2 are 0, and `dbg_mode` is 0.
- R5: When `cop0_dec` is high in a cycle where `user_mode` is 1 and status bit 28 is 0, `cpu_exc` is 1 for the following cycle only, with `cpu_exc_ce` equal to 0. In every other case `cpu_exc` stays 0.
- R6: While `rst_n` is low the status word is 32'h0040_0004 (bit 22 and bit 2 set, all others 0), and `irq_req` and `cpu_exc` are 0.
- R7: A decode that arrives in the same cycle as a status write is judged against the status value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 32 | Status write value |
| st_rd_data | output | 32 | Stored status value |
| cause_ip | input | 8 | Pending interrupt lines (cause bits 15:8) |
| dbg_mode | input | 1 | Debug mode is active |
| cop0_dec | input | 1 | A system-coprocessor instruction was decoded this cycle |
| irq_req | output | 1 | Registered hardware interrupt request level |
| user_mode | output | 1 | Effective user privilege |
| cpu_exc | output | 1 | Coprocessor-unusable exception strobe |
| cpu_exc_ce | output | 2 | Coprocessor number for the exception, always 0 |

## Verification
The hardest case to reach is the unusable-coprocessor trap. It needs user mode set, both exception levels clear, debug off, the coprocessor-0 usable bit clear, and a decode strobe, all at the same edge. The reset value sets the error level, so plain random writes almost never open this path. The stimulus therefore biases status writes: it clears bits 1, 2 and 28, sets bit 4 and holds `dbg_mode` low most of the time. Directed steps cover a write colliding with a decode, and an interrupt being dropped while its line stays pending.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int XLEN     = 32;
  localparam int NIP      = 8;
  localparam int B_IE     = 0;
  localparam int B_EXL    = 1;
  localparam int B_ERL    = 2;
  localparam int B_UM     = 4;
  localparam int B_IM_LO  = 8;
  localparam int B_BEV    = 22;
  localparam int B_CU0    = 28;
  localparam logic [XLEN-1:0] ST_WMASK = 32'hF878_FF17;
  localparam logic [XLEN-1:0] ST_RESET = (32'd1 << B_BEV) | (32'd1 << B_ERL);
  localparam int CE_W     = 2;
endpackage

// File: rtl/cp0_status_reg.sv
module cp0_status_reg
  import cp0_pkg::*;
#(
  parameter int W = XLEN,
  parameter logic [W-1:0] WMASK = ST_WMASK,
  parameter logic [W-1:0] RSTV  = ST_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     st_q <= RSTV;
    else if (wr_en) st_q <= wr_data & WMASK;
  end

  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st_q));
endmodule

// File: rtl/cp0_irq_gate.sv
module cp0_irq_gate #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] im,
  input  logic [N-1:0] ip,
  input  logic         ie,
  input  logic         exl,
  input  logic         erl,
  input  logic         dbg,
  output logic         irq_q
);
  logic [N-1:0] pend;
  logic         gate_ok;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign pend[i] = im[i] & ip[i];
  end

  assign gate_ok = ie & ~exl & ~erl & ~dbg;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gate_ok & (|pend);
  end

  assert_irq_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|(im & ip)) && $past(ie));

  assert_irq_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exl || erl || dbg || !ie) |=> !irq_q);
endmodule

// File: rtl/cp0_priv_check.sv
module cp0_priv_check
  import cp0_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            um,
  input  logic            exl,
  input  logic            erl,
  input  logic            cu0,
  input  logic            dbg,
  input  logic            dec,
  output logic            user_mode,
  output logic            exc_q,
  output logic [CE_W-1:0] exc_ce
);
  assign user_mode = um & ~exl & ~erl & ~dbg;

  always_ff @(posedge clk) begin
    if (!rst_n) exc_q <= 1'b0;
    else        exc_q <= dec & user_mode & ~cu0;
  end

  assign exc_ce = '0;

  assert_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> (!dbg && um));

  assert_exc_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> $past(dec) && !$past(cu0) && $past(user_mode));

  assert_exc_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> !exc_q);
endmodule

// File: rtl/cp0_stat_gate.sv
module cp0_stat_gate
  import cp0_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_wr_en,
  input  logic [31:0]     st_wr_data,
  output logic [31:0]     st_rd_data,
  input  logic [7:0]      cause_ip,
  input  logic            dbg_mode,
  input  logic            cop0_dec,
  output logic            irq_req,
  output logic            user_mode,
  output logic            cpu_exc,
  output logic [1:0]      cpu_exc_ce
);
  logic [XLEN-1:0] st_q;

  cp0_status_reg #(.W(XLEN)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr_en), .wr_data(st_wr_data), .st_q(st_q)
  );

  cp0_irq_gate #(.N(NIP)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .im(st_q[B_IM_LO +: NIP]), .ip(cause_ip),
    .ie(st_q[B_IE]), .exl(st_q[B_EXL]), .erl(st_q[B_ERL]),
    .dbg(dbg_mode), .irq_q(irq_req)
  );

  cp0_priv_check u_priv (
    .clk(clk), .rst_n(rst_n),
    .um(st_q[B_UM]), .exl(st_q[B_EXL]), .erl(st_q[B_ERL]), .cu0(st_q[B_CU0]),
    .dbg(dbg_mode), .dec(cop0_dec),
    .user_mode(user_mode), .exc_q(cpu_exc), .exc_ce(cpu_exc_ce)
  );

  assign st_rd_data = st_q;

  assert_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> (st_rd_data & ~ST_WMASK) == '0);
endmodule

// File: tb/sim_cp0_stat_gate.sv
module sim_cp0_stat_gate;
  localparam logic [31:0] MASK = 32'hF878_FF17;
  localparam logic [31:0] RSTV = 32'h0040_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_wr_en = 1'b0;
  logic [31:0] st_wr_data = '0;
  logic [31:0] st_rd_data;
  logic [7:0]  cause_ip = '0;
  logic        dbg_mode = 1'b0;
  logic        cop0_dec = 1'b0;
  logic        irq_req, user_mode, cpu_exc;
  logic [1:0]  cpu_exc_ce;

  int total = 0;
  int bad = 0;
  logic [31:0] m_st;
  logic        m_irq, m_exc;

  always #10 clk = ~clk;

  cp0_stat_gate u0 (.*);

  function automatic logic f_irq(logic [31:0] s, logic [7:0] ip, logic d);
    return (|(s[15:8] & ip)) && s[0] && !s[1] && !s[2] && !d;
  endfunction

  function automatic logic f_user(logic [31:0] s, logic d);
    return s[4] && !s[1] && !s[2] && !d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wen, input logic [31:0] wd, input logic [7:0] ip,
                      input logic d, input logic dec);
    logic [31:0] n_st;
    logic n_irq, n_exc;
    st_wr_en = wen; st_wr_data = wd; cause_ip = ip; dbg_mode = d; cop0_dec = dec;
    #1;
    chk("R4 user_mode", {31'd0, user_mode}, {31'd0, f_user(m_st, d)});
    n_st  = wen ? (wd & MASK) : m_st;
    n_irq = f_irq(m_st, ip, d);
    n_exc = dec && f_user(m_st, d) && !m_st[28];
    @(posedge clk);
    @(negedge clk);
    m_st = n_st; m_irq = n_irq; m_exc = n_exc;
    chk("R3 status", st_rd_data, m_st);
    chk("R1/R2 irq", {31'd0, irq_req}, {31'd0, m_irq});
    chk("R5/R7 exc", {31'd0, cpu_exc}, {31'd0, m_exc});
    if (cpu_exc) chk("R5 ce", {30'd0, cpu_exc_ce}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] wd;
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 status", st_rd_data, RSTV);
    chk("R6 irq", {31'd0, irq_req}, 32'd0);
    chk("R6 exc", {31'd0, cpu_exc}, 32'd0);
    rst_n = 1'b1;
    m_st = RSTV; m_irq = 1'b0; m_exc = 1'b0;
    // R1 pending masked under ERL: no irq
    step(0, 0, 8'hFF, 0, 0);
    // R3 mask
    step(1, 32'hFFFF_FFFF, 8'h00, 0, 0);
    chk("R3 mask", st_rd_data, 32'hF878_FF17);
    // R1 open gate, then line
    step(1, 32'h0000_0101, 8'h00, 0, 0);
    step(0, 0, 8'h01, 0, 0);
    step(0, 0, 8'h01, 0, 0);
    chk("R1 direct", {31'd0, irq_req}, 32'd1);
    // R2 drop on EXL while still pending
    step(1, 32'h0000_0103, 8'h01, 0, 0);
    step(0, 0, 8'h01, 0, 0);
    chk("R2 drop", {31'd0, irq_req}, 32'd0);
    // R2 drop on debug
    step(1, 32'h0000_0101, 8'h01, 0, 0);
    step(0, 0, 8'h01, 1, 0);
    chk("R2 dbg", {31'd0, irq_req}, 32'd0);
    // R5 user trap, and CU0 set suppresses it
    step(1, 32'h0000_0010, 8'h00, 0, 0);
    step(0, 0, 8'h00, 0, 1);
    chk("R5 trap", {31'd0, cpu_exc}, 32'd1);
    step(0, 0, 8'h00, 0, 0);
    chk("R5 single", {31'd0, cpu_exc}, 32'd0);
    // R7 collision: write sets CU0 in decode cycle, old value rules
    step(1, 32'h1000_0010, 8'h00, 0, 1);
    chk("R7 collide", {31'd0, cpu_exc}, 32'd1);
    step(0, 0, 8'h00, 0, 1);
    chk("R5 cu0", {31'd0, cpu_exc}, 32'd0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      wd = $urandom;
      if ($urandom_range(0, 3) != 0) wd = (wd & ~32'h1000_0006) | 32'h0000_0011;
      step($urandom_range(0, 4) == 0, wd, 8'($urandom),
           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule